// File: doc/BRIEF.md
# ATM Cell Header Error Control Unit

This block sits in a byte-wide transmit stream of 53-octet ATM cells. Each beat carries one octet, a valid qualifier and a start-of-cell marker. The block keeps track of each octet's position in its cell. Over the first four header octets it builds a CRC-8 remainder. At the fifth octet it forms the expected header error control (HEC) byte from that remainder. Two static options shape that byte: one adds a fixed coset pattern and the other inverts the result.

The operating mode comes from static control inputs:
- With checking off, every octet passes untouched and no error is ever raised.
- With checking on, the arriving fifth octet is compared with the expected HEC and any mismatch is flagged for one cycle.
- With checking on and regeneration also on, the fifth octet is overwritten with the expected HEC. Errored cells are still forwarded.

The stream always leaves exactly one cycle after it enters. Replacing an octet never stalls the stream and never drops a beat.

Top module: `atm_hec_unit`

## Requirements
- R1: Every input beat appears at the outputs exactly one clock later: out_valid equals the previous cycle's in_valid, and a beat with in_valid low yields out_valid low.
- R2: A valid beat with in_soc high has octet index 0. Each valid beat without in_soc has the index one above the previous valid beat. After index 52 the index wraps to 0 without a marker. Index 4 is the HEC octet. out_soc marks the output beat of a valid input beat that had in_soc high.
- R3: The remainder uses generator x^8+x^2+x+1 (0x07). It is processed most significant bit first, starts from zero at index 0, and covers only indexes 0 to 3. For example, header 00 00 00 01 gives 0x07.
- R4: With cfg_check_en low, all octets leave unchanged and hec_error stays 0, whatever cfg_regen_en is.
- R5: With cfg_check_en high, hec_error is 1 for exactly the output beat of octet 4, and only if the received octet differs from the expected HEC. With cfg_regen_en low, octet 4 leaves unchanged.
- R6: With cfg_check_en and cfg_regen_en both high, octet 4 leaves carrying the expected HEC. A mismatch is still flagged, and all 53 octets of the cell are still forwarded.
- R7: With cfg_coset_en high, the expected HEC is the remainder XOR 0x55.
- R8: With cfg_invert_en high, the expected HEC is bitwise inverted after any coset addition. For example, an all-zero header with both options on gives 0xAA.
- R9: Octets at any index other than 4 are never altered.
- R10: While rst_n is low, out_valid, out_soc and hec_error are 0. After reset the octet index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input octet qualifier |
| in_soc | input | 1 | Input start-of-cell marker |
| in_data | input | 8 | Input octet |
| cfg_check_en | input | 1 | Enable HEC checking |
| cfg_regen_en | input | 1 | Overwrite octet 4 with the expected HEC (only when checking is enabled) |
| cfg_coset_en | input | 1 | Add coset pattern 0x55 to the HEC |
| cfg_invert_en | input | 1 | Invert the HEC byte |
| out_valid | output | 1 | Output octet qualifier |
| out_soc | output | 1 | Output start-of-cell marker |
| out_data | output | 8 | Output octet |
| hec_error | output | 1 | One-cycle pulse on the output beat of a mismatched HEC octet |

## Verification
A drifted octet index shows up in the very next cell. The wrong octet is overwritten or compared, so out_data is corrupted at a payload position and hec_error fires on a beat other than the fifth. A remainder that is not cleared at index 0, or that absorbs a fifth octet, gives a wrong HEC on octet 4 of the following cell. That error is visible one cycle after the octet enters. The sweep covers cells with valid gaps, cells that wrap without a marker and cells cut short by an early marker, because these are where such state errors would appear.

// File: rtl/atm_hec_pkg.sv
package atm_hec_pkg;

  localparam int HEC_W = 8;

  typedef logic [HEC_W-1:0] octet_t;

  // One octet through a CRC-8 divider, most significant bit first.
  function automatic octet_t crc_step(input octet_t rem, input octet_t din,
                                      input octet_t poly);
    octet_t r;
    logic   fb;
    r = rem;
    for (int b = HEC_W - 1; b >= 0; b--) begin
      fb = r[HEC_W-1] ^ din[b];
      r  = {r[HEC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    return r;
  endfunction

endpackage

// File: rtl/atm_hec_octet_ctr.sv
module atm_hec_octet_ctr #(
  parameter int CELL_LEN = 53,
  parameter int CW       = $clog2(CELL_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat_en,
  input  logic          soc,
  output logic [CW-1:0] oct_idx,
  output logic [CW-1:0] cnt_q
);

  localparam logic [CW-1:0] LAST = CW'(CELL_LEN - 1);

  logic [CW-1:0] cnt_d;

  always_comb begin
    oct_idx = soc ? '0 : cnt_q;
    cnt_d   = cnt_q;
    if (beat_en) begin
      cnt_d = (oct_idx == LAST) ? '0 : oct_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (beat_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/atm_hec_crc.sv
module atm_hec_crc
  import atm_hec_pkg::*;
#(
  parameter octet_t POLY = 8'h07
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   step_en,
  input  logic   restart,
  input  octet_t din,
  output octet_t crc_q
);

  octet_t crc_d;

  always_comb begin
    crc_d = crc_step(restart ? '0 : crc_q, din, POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else if (step_en) begin
      crc_q <= crc_d;
    end
  end

endmodule

// File: rtl/atm_hec_finish.sv
module atm_hec_finish
  import atm_hec_pkg::*;
#(
  parameter octet_t COSET = 8'h55
) (
  input  octet_t crc,
  input  logic   coset_en,
  input  logic   invert_en,
  output octet_t hec
);

  octet_t with_coset;

  always_comb begin
    with_coset = crc ^ (coset_en ? COSET : '0);
    hec        = invert_en ? ~with_coset : with_coset;
  end

endmodule

// File: rtl/atm_hec_unit.sv
module atm_hec_unit
  import atm_hec_pkg::*;
#(
  parameter int     CELL_LEN = 53,
  parameter int     HDR_LEN  = 4,
  parameter octet_t POLY     = 8'h07,
  parameter octet_t COSET    = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_soc,
  input  logic [7:0] in_data,
  input  logic       cfg_check_en,
  input  logic       cfg_regen_en,
  input  logic       cfg_coset_en,
  input  logic       cfg_invert_en,
  output logic       out_valid,
  output logic       out_soc,
  output logic [7:0] out_data,
  output logic       hec_error
);

  localparam int            CW      = $clog2(CELL_LEN);
  localparam logic [CW-1:0] HEC_POS = CW'(HDR_LEN);

  logic [CW-1:0] oct_idx;
  logic [CW-1:0] cnt_q;
  logic          hdr_beat;
  logic          first_beat;
  logic          hec_beat;
  octet_t        crc_q;
  octet_t        hec_exp;

  logic          valid_d, soc_d, err_d;
  octet_t        data_d;

  atm_hec_octet_ctr #(.CELL_LEN(CELL_LEN), .CW(CW)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat_en (in_valid),
    .soc     (in_soc),
    .oct_idx (oct_idx),
    .cnt_q   (cnt_q)
  );

  assign hdr_beat   = in_valid && (oct_idx < HEC_POS);
  assign first_beat = (oct_idx == '0);
  assign hec_beat   = in_valid && (oct_idx == HEC_POS);

  atm_hec_crc #(.POLY(POLY)) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (hdr_beat),
    .restart (first_beat),
    .din     (in_data),
    .crc_q   (crc_q)
  );

  atm_hec_finish #(.COSET(COSET)) u_fin (
    .crc       (crc_q),
    .coset_en  (cfg_coset_en),
    .invert_en (cfg_invert_en),
    .hec       (hec_exp)
  );

  // Next-state for the output stage.
  always_comb begin
    valid_d = in_valid;
    soc_d   = in_valid && in_soc;
    err_d   = hec_beat && cfg_check_en && (in_data != hec_exp);
    data_d  = (hec_beat && cfg_check_en && cfg_regen_en) ? hec_exp : in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_soc   <= 1'b0;
      hec_error <= 1'b0;
    end else begin
      out_valid <= valid_d;
      out_soc   <= soc_d;
      hec_error <= err_d;
    end
  end

  // Data path register: loaded only on valid beats.
  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_data <= data_d;
    end
  end

endmodule

// File: rtl/atm_hec_chk.sv
module atm_hec_chk #(
  parameter int CELL_LEN = 53,
  parameter int HDR_LEN  = 4,
  parameter int CW       = $clog2(CELL_LEN)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_soc,
  input logic [7:0]    in_data,
  input logic          cfg_check_en,
  input logic          out_valid,
  input logic [7:0]    out_data,
  input logic          hec_error,
  input logic [CW-1:0] oct_idx,
  input logic [CW-1:0] cnt_q
);

  localparam logic [CW-1:0] HEC_POS = CW'(HDR_LEN);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_ctr_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(CELL_LEN));

  assert_soc_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_soc) |-> (oct_idx == '0));

  assert_nocheck_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_check_en) |=> (out_data == $past(in_data) && !hec_error));

  assert_err_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hec_error |=> !hec_error);

  assert_err_on_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hec_error |-> out_valid);

  assert_other_octets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && oct_idx != HEC_POS) |=> (out_data == $past(in_data)));

endmodule

bind atm_hec_unit atm_hec_chk #(.CELL_LEN(CELL_LEN), .HDR_LEN(HDR_LEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_soc       (in_soc),
  .in_data      (in_data),
  .cfg_check_en (cfg_check_en),
  .out_valid    (out_valid),
  .out_data     (out_data),
  .hec_error    (hec_error),
  .oct_idx      (oct_idx),
  .cnt_q        (cnt_q)
);

// File: tb/sim_atm_hec_unit.sv
`timescale 1ns/1ps
module sim_atm_hec_unit;

  localparam real CLK_NS = 5.0;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_soc;
  logic [7:0] in_data;
  logic       chk, regen, coset, inv;
  logic       out_valid, out_soc, hec_error;
  logic [7:0] out_data;

  int unsigned checks = 0;
  int unsigned fails  = 0;
  bit          done   = 1'b0;

  always #(CLK_NS / 2.0) clk = ~clk;

  atm_hec_unit u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_soc        (in_soc),
    .in_data       (in_data),
    .cfg_check_en  (chk),
    .cfg_regen_en  (regen),
    .cfg_coset_en  (coset),
    .cfg_invert_en (inv),
    .out_valid     (out_valid),
    .out_soc       (out_soc),
    .out_data      (out_data),
    .hec_error     (hec_error)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Polynomial long division of header*x^8 by 0x107.
  function automatic logic [7:0] model_crc(input logic [7:0] h [4]);
    logic [39:0] r;
    r = {h[0], h[1], h[2], h[3], 8'h00};
    for (int i = 39; i >= 8; i--) begin
      if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
    end
    return r[7:0];
  endfunction

  function automatic logic [7:0] model_hec(input logic [7:0] h [4]);
    logic [7:0] v;
    v = model_crc(h) ^ (coset ? 8'h55 : 8'h00);
    return inv ? ~v : v;
  endfunction

  task automatic beat(input logic v, input logic s, input logic [7:0] d);
    @(negedge clk);
    in_valid = v;
    in_soc   = s;
    in_data  = d;
    @(posedge clk);
    #1;
  endtask

  task automatic idle_beat();
    beat(1'b0, 1'b0, 8'h00);
    check(out_valid == 1'b0, "R1", "out_valid on idle", out_valid, 0);
    check(hec_error == 1'b0, "R5", "hec_error on idle", hec_error, 0);
  endtask

  task automatic send_cell(input logic [7:0] h [4], input logic [7:0] hec_rx,
                           input bit use_soc, input bit gaps);
    logic [7:0] exph, d, expd;
    bit         experr;
    string      dtag;
    exph = model_hec(h);
    for (int k = 0; k < 53; k++) begin
      if (gaps && (k % 7 == 3)) idle_beat();
      d = (k < 4) ? h[k] : (k == 4) ? hec_rx : 8'($urandom);
      expd   = (k == 4 && chk && regen) ? exph : d;
      experr = chk && (k == 4) && (hec_rx != exph);
      beat(1'b1, use_soc && (k == 0), d);
      dtag = (k != 4) ? "R9" : !chk ? "R4" : regen ? "R6" : "R5";
      check(out_valid == 1'b1, "R1", "out_valid", out_valid, 1);
      check(out_soc == (use_soc && k == 0), "R2", "out_soc", out_soc,
            int'(use_soc && k == 0));
      check(out_data == expd, dtag, $sformatf("out_data octet %0d", k),
            out_data, expd);
      check(hec_error == experr, chk ? "R5" : "R4",
            $sformatf("hec_error octet %0d", k), hec_error, experr);
    end
  endtask

  task automatic directed_hec(input logic [7:0] h [4], input logic [7:0] want,
                              input string req);
    for (int k = 0; k < 5; k++) begin
      beat(1'b1, k == 0, (k < 4) ? h[k] : 8'h00);
    end
    check(out_data == want, req, "regenerated HEC", out_data, want);
    for (int k = 5; k < 53; k++) beat(1'b1, 1'b0, 8'h00);
  endtask

  initial begin
    #(CLK_NS * 150000.0);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] h [4];
    logic [7:0] good;
    rst_n = 1'b0; in_valid = 1'b0; in_soc = 1'b0; in_data = 8'h00;
    chk = 1'b1; regen = 1'b1; coset = 1'b0; inv = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
    check(out_soc == 1'b0,   "R10", "out_soc in reset", out_soc, 0);
    check(hec_error == 1'b0, "R10", "hec_error in reset", hec_error, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: index starts at 0 after reset, so a cell without a marker is aligned.
    foreach (h[i]) h[i] = 8'($urandom);
    send_cell(h, 8'h00, 1'b0, 1'b0);

    // R3: header 00 00 00 01 gives 0x07.
    h = '{8'h00, 8'h00, 8'h00, 8'h01};
    directed_hec(h, 8'h07, "R3");
    // R7, R8: all-zero header with options.
    h = '{8'h00, 8'h00, 8'h00, 8'h00};
    coset = 1'b1; directed_hec(h, 8'h55, "R7");
    coset = 1'b0; inv = 1'b1; directed_hec(h, 8'hFF, "R8");
    coset = 1'b1; directed_hec(h, 8'hAA, "R8");

    // Sweep all option combinations.
    for (int c = 0; c < 16; c++) begin
      {chk, regen, coset, inv} = 4'(c);
      for (int n = 0; n < 3; n++) begin
        foreach (h[i]) h[i] = 8'($urandom);
        good = model_hec(h);
        send_cell(h, good, 1'b1, 1'b0);
        foreach (h[i]) h[i] = 8'($urandom);
        good = model_hec(h);
        send_cell(h, good ^ 8'(1 << n), 1'b1, n == 1);
        // R2: next cell follows without a marker after index 52 wraps.
        foreach (h[i]) h[i] = 8'($urandom);
        send_cell(h, 8'($urandom), 1'b0, n == 2);
      end
      // R2: a marker in mid-cell restarts the index.
      for (int k = 0; k < 9; k++) beat(1'b1, k == 0, 8'($urandom));
      foreach (h[i]) h[i] = 8'($urandom);
      send_cell(h, model_hec(h), 1'b1, 1'b0);
      idle_beat();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule